// File: doc/BRIEF.md
# Charge-Pump Lock Detector with Hysteresis

This block watches the up and down pulses of a phase-locked loop's charge pump and keeps a lock flag. It runs on the crystal clock. It treats the pump as active in any cycle where either pulse is high, and it measures how many consecutive crystal cycles the pump stays active. A burst that lasts longer than the width limit clears the flag on the very edge that sees the excess cycle. One crystal cycle is the default limit.

A strobe marks the last crystal cycle of every reference period. A period counts as clean if it ends without any over-long burst. This includes a period with no pump activity at all. The flag is set again only when a run of consecutive clean periods reaches the required length, which is eight by default. Losing lock is reported at once, but regaining lock takes several full reference periods. The two directions are deliberately unequal.

Top module: `lock_detect_hyst`

## Requirements
- R1: Out of reset, and while reset is asserted, `lock_flag` is 0 and the clean-period count is zero.
- R2: A pump burst of at most WIDTH_LIMIT consecutive active cycles (default 1) never clears `lock_flag`.
- R3: When the pump is active for WIDTH_LIMIT+1 consecutive cycles, `lock_flag` reads 0 right after the clock edge that samples the last of those cycles. No reference strobe is needed for this.
- R4: `pump_up` and `pump_dn` are combined with OR for width measurement. A wide burst made only of down pulses, or of an up cycle followed directly by a down cycle, clears the flag in the same way as an up burst.
- R5: `lock_flag` rises only on the edge that samples `ref_tick` completing the CLEAN_RUN-th consecutive clean period (default 8). It stays 0 after the CLEAN_RUN-1-th.
- R6: A reference period with no pump activity counts as clean.
- R7: Any wide burst resets the consecutive clean-period count to zero. After CLEAN_RUN-1 clean periods, one dirty period means CLEAN_RUN further clean periods are needed.
- R8: While locked, clean periods keep the flag at 1. A wide burst in the middle of a period clears it before that period's strobe.
- R9: A wide burst whose excess cycle falls in the same cycle as `ref_tick` makes that period dirty.
- R10: Several separate narrow bursts within one period leave that period clean.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pump_up | input | 1 | Charge-pump up pulse, synchronous to clk |
| pump_dn | input | 1 | Charge-pump down pulse, synchronous to clk |
| ref_tick | input | 1 | One-cycle strobe marking the final cycle of a reference period |
| lock_flag | output | 1 | 1 when the loop is judged locked |

## Verification
The stimulus uses idle periods, single-cycle up pulses, and trains of separated narrow pulses, all of which must keep or build lock. It also uses two-cycle bursts on up, on down, and alternating up then down, each of which must drop the flag on the exact edge. One acquisition is interrupted after seven clean periods to show that the count restarts rather than resuming. A wide burst placed on the strobe cycle shows that the excess cycle is judged against the period it closes. A cycle-accurate behavioural model compares the flag on every clock, so an off-by-one in the width threshold or the run length shows up as a one-cycle or one-period mismatch.

// File: rtl/lkd_pkg.sv
// Shared types for the lock detector.
// The period verdict passes from the period judge to the run counter.
package lkd_pkg;
    typedef enum logic [1:0] {
        VERDICT_NONE  = 2'd0,
        VERDICT_CLEAN = 2'd1,
        VERDICT_DIRTY = 2'd2
    } verdict_t;
endpackage

// File: rtl/lkd_width_meter.sv
// Width meter: counts consecutive crystal cycles in which the pump is active
// (up OR down) and flags the cycle in which the run exceeds WIDTH_LIMIT.
// Assumes pump inputs are already synchronous to clk and WIDTH_LIMIT >= 1.
module lkd_width_meter #(
    parameter int WIDTH_LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pump_up,
    input  logic pump_dn,
    output logic wide_now
);
    localparam int LEN_W = $clog2(WIDTH_LIMIT + 2);
    localparam logic [LEN_W-1:0] LIMIT_V = LEN_W'(WIDTH_LIMIT);
    localparam logic [LEN_W-1:0] SAT_V   = LEN_W'(WIDTH_LIMIT + 1);

    logic             pump_active;
    logic [LEN_W-1:0] run_len;

    // Purpose: either pump direction counts as activity.
    always_comb pump_active = pump_up | pump_dn;

    // Purpose: this cycle is beyond the allowed width when enough active cycles precede it.
    always_comb wide_now = pump_active && (run_len >= LIMIT_V);

    // Purpose: track the length of the current active run, saturating past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (!pump_active) begin
            run_len <= '0;
        end else if (run_len < SAT_V) begin
            run_len <= run_len + 1'b1;
        end
    end

    // After an idle cycle, a single active cycle can never be over the limit.
    assert_short_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_active |=> !wide_now);
endmodule

// File: rtl/lkd_period_judge.sv
// Period judge: remembers whether any wide burst happened in the current
// reference period and issues a verdict on the strobe cycle.
// Assumes ref_tick is a single-cycle pulse on the last cycle of each period.
module lkd_period_judge
    import lkd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ref_tick,
    input  logic     wide_now,
    output verdict_t verdict
);
    logic dirty_q;

    // Purpose: a period is dirty if a wide cycle was seen earlier or is seen now.
    always_comb begin
        if (!ref_tick)                 verdict = VERDICT_NONE;
        else if (dirty_q || wide_now)  verdict = VERDICT_DIRTY;
        else                           verdict = VERDICT_CLEAN;
    end

    // Purpose: hold the dirty mark until the strobe closes the period.
    always_ff @(posedge clk) begin
        if (!rst_n)        dirty_q <= 1'b0;
        else if (ref_tick) dirty_q <= 1'b0;
        else if (wide_now) dirty_q <= 1'b1;
    end

    // A wide cycle that does not close the period must be remembered for the strobe.
    assert_dirty_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_now && !ref_tick) |=> dirty_q);
endmodule

// File: rtl/lkd_run_counter.sv
// Run counter: counts consecutive clean reference periods and owns the lock
// flag. A wide cycle clears both at once; the flag is set when the count reaches
// CLEAN_RUN. Assumes CLEAN_RUN >= 1.
module lkd_run_counter
    import lkd_pkg::*;
#(
    parameter int CLEAN_RUN = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wide_now,
    input  verdict_t                     verdict,
    output logic                         lock_flag,
    output logic [$clog2(CLEAN_RUN+1)-1:0] clean_cnt
);
    localparam int CNT_W = $clog2(CLEAN_RUN + 1);
    localparam logic [CNT_W-1:0] RUN_V = CNT_W'(CLEAN_RUN);

    logic [CNT_W-1:0] next_cnt;

    // Purpose: saturating successor of the clean-period count.
    always_comb next_cnt = (clean_cnt >= RUN_V) ? RUN_V : clean_cnt + 1'b1;

    // Purpose: update run length and flag; a wide cycle takes priority over any verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_cnt <= '0;
            lock_flag <= 1'b0;
        end else if (wide_now) begin
            clean_cnt <= '0;
            lock_flag <= 1'b0;
        end else begin
            case (verdict)
                VERDICT_CLEAN: begin
                    clean_cnt <= next_cnt;
                    if (next_cnt == RUN_V) lock_flag <= 1'b1;
                end
                VERDICT_DIRTY: clean_cnt <= '0;
                default: ;
            endcase
        end
    end

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clean_cnt <= RUN_V);
    assert_wide_resets_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wide_now |=> (clean_cnt == '0));
    assert_wide_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wide_now |=> !lock_flag);
    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flag && !wide_now) |=> lock_flag);
endmodule

// File: rtl/lock_detect_hyst.sv
// Lock detector top: width meter -> period judge -> run counter.
// Clears the lock flag as soon as a pump burst is too wide; sets it only after
// CLEAN_RUN consecutive clean reference periods. Runs entirely on the crystal clock.
module lock_detect_hyst
    import lkd_pkg::*;
#(
    parameter int WIDTH_LIMIT = 1,
    parameter int CLEAN_RUN   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pump_up,
    input  logic pump_dn,
    input  logic ref_tick,
    output logic lock_flag
);
    localparam int CNT_W = $clog2(CLEAN_RUN + 1);

    logic             wide_now;
    verdict_t         verdict;
    logic [CNT_W-1:0] clean_cnt;

    lkd_width_meter #(.WIDTH_LIMIT(WIDTH_LIMIT)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .wide_now (wide_now)
    );

    lkd_period_judge u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .wide_now (wide_now),
        .verdict  (verdict)
    );

    lkd_run_counter #(.CLEAN_RUN(CLEAN_RUN)) u_runner (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_now  (wide_now),
        .verdict   (verdict),
        .lock_flag (lock_flag),
        .clean_cnt (clean_cnt)
    );

    // The flag may only rise on the edge that sampled a reference strobe.
    assert_rise_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(ref_tick));
    // A strobe that closes a clean period must advance the count (or keep it saturated).
    assert_clean_advances_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && !wide_now && verdict == VERDICT_CLEAN) |=> (clean_cnt != '0));
endmodule

// File: tb/lock_detect_hyst_bench.sv
// Bench: drives pump and strobe patterns, keeps a behavioural model of the
// flag, and compares on every clock at the falling edge.
module lock_detect_hyst_bench;
    localparam int LIMIT = 1;
    localparam int RUN   = 8;
    localparam int PER   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pump_up = 1'b0, pump_dn = 1'b0, ref_tick = 1'b0;
    logic lock_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // model state
    int  m_run = 0, m_cnt = 0;
    bit  m_dirty = 0, m_flag = 0;

    lock_detect_hyst #(.WIDTH_LIMIT(LIMIT), .CLEAN_RUN(RUN)) u_lock_detect_hyst (
        .clk(clk), .rst_n(rst_n), .pump_up(pump_up), .pump_dn(pump_dn),
        .ref_tick(ref_tick), .lock_flag(lock_flag)
    );

    always #4 clk = ~clk;

    // Behavioural model, updated from the inputs sampled at each rising edge.
    always @(posedge clk) begin
        bit act, wide;
        cycles++;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_dirty = 0; m_flag = 0;
        end else begin
            act  = pump_up || pump_dn;
            wide = act && (m_run >= LIMIT);
            m_run = act ? ((m_run < LIMIT + 1) ? m_run + 1 : m_run) : 0;
            if (wide) begin m_cnt = 0; m_flag = 0; end
            if (ref_tick) begin
                if (m_dirty || wide) m_cnt = 0;
                else begin
                    if (m_cnt < RUN) m_cnt++;
                    if (m_cnt >= RUN && !wide) m_flag = 1;
                end
                m_dirty = 0;
            end else if (wide) m_dirty = 1;
        end
    end

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s lock_flag actual %0b expected %0b at cycle %0d", req, got, exp, cycles);
        end
    endtask

    // One cycle: compare against the model, then drive the next inputs.
    task automatic step(input bit up, input bit dn, input bit tk);
        @(negedge clk);
        check(cur_req, lock_flag, m_flag);
        pump_up = up; pump_dn = dn; ref_tick = tk;
    endtask

    // One reference period with a single burst; mode 0 up, 1 down, 2 alternating.
    task automatic period(input int start, input int len, input int mode);
        for (int i = 0; i < PER; i++) begin
            bit act = (i >= start) && (i < start + len);
            bit alt = ((i - start) % 2) == 1;
            bit up = act && (mode == 0 || (mode == 2 && !alt));
            bit dn = act && (mode == 1 || (mode == 2 && alt));
            step(up, dn, i == PER - 1);
        end
    endtask

    // One period with narrow pulses every fourth cycle.
    task automatic narrow_train();
        for (int i = 0; i < PER; i++)
            step((i % 4) == 1, (i % 4) == 3 && i > 8, i == PER - 1);
    endtask

    task automatic idle_periods(input int n);
        for (int k = 0; k < n; k++) period(0, 0, 0);
    endtask

    // Let the final driven inputs reach the design, then check directly.
    task automatic settle_check(input string req, input logic exp);
        step(0, 0, 0);
        check(req, lock_flag, exp);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) step(1, 0, 1);
        check("R1", lock_flag, 1'b0);
        @(negedge clk); rst_n = 1'b1; pump_up = 0; ref_tick = 0;

        // R6/R5: acquisition from idle periods
        cur_req = "R5";
        idle_periods(RUN - 1);
        settle_check("R5", 1'b0);
        idle_periods(1);
        settle_check("R5", 1'b1);

        // R2, R10: narrow activity keeps lock
        cur_req = "R2";
        period(5, 1, 0);
        settle_check("R2", 1'b1);
        cur_req = "R10";
        narrow_train();
        narrow_train();
        settle_check("R10", 1'b1);

        // R3/R8: two-cycle up burst mid-period clears immediately
        cur_req = "R3";
        step(1, 0, 0);
        step(1, 0, 0);
        step(0, 0, 0);
        check("R3", lock_flag, 1'b0);
        step(0, 0, 1);
        idle_periods(RUN);
        settle_check("R6", 1'b1);

        // R4: down-only wide burst, then up-then-down burst
        cur_req = "R4";
        period(3, 2, 1);
        settle_check("R4", 1'b0);
        idle_periods(RUN);
        settle_check("R4", 1'b1);
        period(7, 2, 2);
        settle_check("R4", 1'b0);

        // R7: seven clean, one dirty, then a full run again
        cur_req = "R7";
        idle_periods(RUN - 1);
        period(2, 3, 0);
        idle_periods(RUN - 1);
        settle_check("R7", 1'b0);
        idle_periods(1);
        settle_check("R7", 1'b1);

        // R9: excess cycle on the strobe cycle makes that period dirty
        cur_req = "R9";
        period(PER - 2, 2, 0);
        settle_check("R9", 1'b0);
        idle_periods(RUN - 1);
        settle_check("R9", 1'b0);
        idle_periods(1);
        settle_check("R9", 1'b1);

        // R8: locked flag survives a long clean stretch
        cur_req = "R8";
        idle_periods(3);
        settle_check("R8", 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule